// File: doc/BRIEF.md
# Nine-Pin General-Purpose I/O Port with Alternate Functions

This block drives nine general-purpose pads, numbered 0 to 7 and 11. Software sets each pin's direction, output value and interrupt enable through a small register port, and reads back a filtered copy of every pad level. Each input passes through a two-flop synchronizer. After that a pulse-width filter ignores any level that does not hold for `MIN_PULSE_CYC` clock cycles. At the default of 10 cycles and a 5 ns clock, this is the 50 ns minimum width for asynchronous inputs. A change of filtered level on a pin whose interrupt is enabled sets a sticky status bit. The interrupt output is the OR of the status bits whose enables are set.

Five configuration bits move fixed pins over to alternate functions. Pin 0 and pin 1 become active-low reset outputs for downstream ports 2 and 4. Pin 7 becomes an active-low event output. Pins 2 and 4 become active-low expander interrupt inputs. An enabled alternate function sets the pin direction and the pin value itself. While it is enabled, the direction and data registers have no effect on that pin. Pad tri-state is represented by an output-enable per pin.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset the following hold. Every `pad_oe` bit is 0. All registers read 0. `irq` is 0. Both `expint0_n` and `expint2_n` are 1.
- R2: A pin with no alternate function and direction bit 1 has `pad_oe`=1 and drives `pad_out` with its output-data bit. A pin with direction bit 0 has `pad_oe`=0.
- R3: The input register shows the filtered pad level. A stable change at a pad does not appear in it within 3 cycles, and does appear within `MIN_PULSE_CYC`+4 cycles.
- R4: A pad pulse shorter than `MIN_PULSE_CYC` cycles leaves the input register and the status unchanged. A pulse of exactly `MIN_PULSE_CYC` cycles is recognised.
- R5: A status bit is set by each rising and each falling change of that pin's filtered level, but only while the pin's interrupt-enable bit is 1.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it as it is. If a new change and a clearing write fall on the same clock edge, the bit stays set.
- R7: `irq` is 1 exactly when some status bit and its enable bit are both 1. Clearing the enable drops `irq` and keeps the status bit.
- R8: Alternate bit 0 turns pin 0 into an output driven with the inverse of `port2_rst_req`. Alternate bit 1 does the same for pin 1 with `port4_rst_req`. In both cases the direction and data registers are ignored.
- R9: Alternate bit 4 turns pin 7 into an output driven with the inverse of `gpe_req`, ignoring the direction and data registers.
- R10: Alternate bit 2 makes pin 2 an input even when its direction bit is 1, and `expint0_n` then follows the filtered level of pin 2. Alternate bit 3 does the same for pin 4 and `expint2_n`. With its alternate bit clear, each of these outputs is 1.
- R11: The register map is as follows. Address 0 holds direction (1 = output). Address 1 holds output data. Address 2 holds input (read only). Address 3 holds interrupt enable. Address 4 holds status. Address 5 holds the alternate enables in bits 4:0, with upper bits reading 0. Other addresses read 0. In the pin registers, data bit k is pin k for k < 8, and bit 8 is pin 11. `rd_valid` and `rd_data` appear one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 9 | Write data, one bit per pin |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 9 | Read data |
| pad_in | input | 9 | Pad input levels (asynchronous) |
| pad_out | output | 9 | Pad output values |
| pad_oe | output | 9 | Pad output enables |
| port2_rst_req | input | 1 | Reset request for downstream port 2 (active high) |
| port4_rst_req | input | 1 | Reset request for downstream port 4 (active high) |
| gpe_req | input | 1 | Event request (active high) |
| expint0_n | output | 1 | Expander interrupt 0 from pin 2, active low |
| expint2_n | output | 1 | Expander interrupt 2 from pin 4, active low |
| irq | output | 1 | Aggregate interrupt |

## Verification
A filtered level change on an enabled pin and a software write-1-to-clear of the same status bit can land on the same clock edge. The bench provokes this case deliberately. It changes pad 3 on a known falling edge, then counts the register stages: two synchronizer flops, `MIN_PULSE_CYC` filter cycles and one change flag. It places the clearing write on the edge where the status bit would be set. The status register is read back afterwards, and the bit must still be 1. A second clearing write one cycle later must then bring the bit to 0.

// File: rtl/gpio_altfn_pkg.sv
// Shared constants for the GPIO port: pin count, register selects and
// the fixed alternate-function map. Assumes the nine-pin layout.
package gpio_altfn_pkg;
    localparam int NPINS = 9;
    localparam int NALT  = 5;

    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_OUT  = 3'd1,
        SEL_IN   = 3'd2,
        SEL_IEN  = 3'd3,
        SEL_STAT = 3'd4,
        SEL_ALT  = 3'd5
    } reg_sel_e;

    // Vector bit driven or read by each alternate function.
    localparam int ALT_PIN [NALT] = '{0, 1, 2, 4, 7};
    // 1 = the alternate function is an output, 0 = an input.
    localparam logic [NALT-1:0] ALT_IS_OUT = 5'b10011;
endpackage

// File: rtl/gpio_in_filter.sv
// One pad input: two-flop synchronizer followed by a pulse-width filter.
// The filtered level takes a new value only after the synchronized level
// has differed from it for MIN_CYC consecutive cycles. 'changed' pulses
// one cycle after each update. Assumes pad_raw is asynchronous.
module gpio_in_filter #(
    parameter int MIN_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_raw,
    output logic level,
    output logic changed
);
    localparam int CNT_W = $clog2(MIN_CYC) + 1;

    logic             s1, s2;
    logic [CNT_W-1:0] cnt;

    // Bring the pad level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= pad_raw;
            s2 <= s1;
        end
    end

    // Accept a new level only after it has held for MIN_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b0;
            cnt     <= '0;
            changed <= 1'b0;
        end else begin
            changed <= 1'b0;
            if (s2 != level) begin
                if (cnt == CNT_W'(MIN_CYC - 1)) begin
                    level   <= s2;
                    cnt     <= '0;
                    changed <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/gpio_regs.sv
// Register file: direction, output data, interrupt enable, sticky status
// (write 1 to clear, a new change wins over a clear) and alternate
// enables. Reads return data one cycle after rd_en. Assumes a single
// access per cycle.
module gpio_regs
    import gpio_altfn_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic [NPINS-1:0]  in_level,
    input  logic [NPINS-1:0]  in_changed,
    output logic              rd_valid,
    output logic [NPINS-1:0]  rd_data,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  dout_q,
    output logic [NPINS-1:0]  ien_q,
    output logic [NPINS-1:0]  stat_q,
    output logic [NALT-1:0]   alt_q,
    output logic              irq
);
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] rd_mux;

    // Status bits selected for clearing by this cycle's write.
    always_comb begin
        clr_mask = (wr_en && addr == ADDR_W'(SEL_STAT)) ? wr_data : '0;
    end

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            ien_q  <= '0;
            alt_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(SEL_DIR): dir_q  <= wr_data;
                ADDR_W'(SEL_OUT): dout_q <= wr_data;
                ADDR_W'(SEL_IEN): ien_q  <= wr_data;
                ADDR_W'(SEL_ALT): alt_q  <= wr_data[NALT-1:0];
                default: ;
            endcase
        end
    end

    // Sticky status: set by enabled level changes, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | (in_changed & ien_q);
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            ADDR_W'(SEL_DIR):  rd_mux = dir_q;
            ADDR_W'(SEL_OUT):  rd_mux = dout_q;
            ADDR_W'(SEL_IN):   rd_mux = in_level;
            ADDR_W'(SEL_IEN):  rd_mux = ien_q;
            ADDR_W'(SEL_STAT): rd_mux = stat_q;
            ADDR_W'(SEL_ALT):  rd_mux = NPINS'(alt_q);
            default:           rd_mux = '0;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_mux : '0;
        end
    end

    // Aggregate interrupt.
    always_comb irq = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_pad_mux.sv
// Pad steering: GPIO direction and data by default. An enabled output
// alternate function forces its pin to drive the inverted request, and
// an enabled input alternate function forces its pin to input and
// presents the filtered level on an active-low output. Assumes the
// package map.
module gpio_pad_mux
    import gpio_altfn_pkg::*;
(
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] dout_q,
    input  logic [NALT-1:0]  alt_q,
    input  logic [NALT-1:0]  alt_req,
    input  logic [NPINS-1:0] in_level,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NALT-1:0]  alt_in_n
);
    // Apply the alternate-function overrides on top of GPIO control.
    always_comb begin
        pad_oe   = dir_q;
        pad_out  = dout_q;
        alt_in_n = '1;
        for (int a = 0; a < NALT; a++) begin
            if (alt_q[a]) begin
                if (ALT_IS_OUT[a]) begin
                    pad_oe[ALT_PIN[a]]  = 1'b1;
                    pad_out[ALT_PIN[a]] = ~alt_req[a];
                end else begin
                    pad_oe[ALT_PIN[a]]  = 1'b0;
                    alt_in_n[a]         = in_level[ALT_PIN[a]];
                end
            end
        end
    end
endmodule

// File: rtl/gpio_altfn_port.sv
// Top of the nine-pin GPIO port with alternate functions. Wires one
// input filter per pin, the register file and the pad steering.
// Assumes pads are asynchronous and the clock period sets MIN_PULSE_CYC.
module gpio_altfn_port
    import gpio_altfn_pkg::*;
#(
    parameter int MIN_PULSE_CYC = 10,
    parameter int ADDR_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic              rd_valid,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic              port2_rst_req,
    input  logic              port4_rst_req,
    input  logic              gpe_req,
    output logic              expint0_n,
    output logic              expint2_n,
    output logic              irq
);
    logic [NPINS-1:0] in_level, in_changed;
    logic [NPINS-1:0] dir_q, dout_q, ien_q, stat_q;
    logic [NALT-1:0]  alt_q, alt_req, alt_in_n;

    // One synchronizer and pulse filter per pin.
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_in_filter #(.MIN_CYC(MIN_PULSE_CYC)) i_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_raw (pad_in[p]),
            .level   (in_level[p]),
            .changed (in_changed[p])
        );
    end

    gpio_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .in_level   (in_level),
        .in_changed (in_changed),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .dir_q      (dir_q),
        .dout_q     (dout_q),
        .ien_q      (ien_q),
        .stat_q     (stat_q),
        .alt_q      (alt_q),
        .irq        (irq)
    );

    // Request vector in alternate-function order (input slots unused).
    always_comb alt_req = {gpe_req, 1'b0, 1'b0, port4_rst_req, port2_rst_req};

    gpio_pad_mux i_mux (
        .dir_q    (dir_q),
        .dout_q   (dout_q),
        .alt_q    (alt_q),
        .alt_req  (alt_req),
        .in_level (in_level),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .alt_in_n (alt_in_n)
    );

    // Expander interrupt outputs.
    always_comb begin
        expint0_n = alt_in_n[2];
        expint2_n = alt_in_n[3];
    end
endmodule

// File: rtl/gpio_altfn_checker.sv
// Assertions for gpio_altfn_port, attached with bind. Observes ports and
// register state. Assumes the default package map.
module gpio_altfn_checker
    import gpio_altfn_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_valid,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic              port2_rst_req,
    input logic              gpe_req,
    input logic              expint0_n,
    input logic [NALT-1:0]   alt_q,
    input logic [NPINS-1:0]  ien_q,
    input logic [NPINS-1:0]  stat_q,
    input logic              irq
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && !irq && expint0_n));

    p_rst2_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alt_q[0] |-> (pad_oe[0] && pad_out[0] == !port2_rst_req));

    p_gpe_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alt_q[4] |-> (pad_oe[7] && pad_out[7] == !gpe_req));

    p_exp_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alt_q[2] |-> !pad_oe[2]);

    p_exp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_q[2] |-> expint0_n);

    p_irq_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ien_q) == '0) |-> !irq);

    p_irq_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ien_q) != '0) |-> irq);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(SEL_STAT)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_set_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ien_q)) == '0));

    p_read_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

bind gpio_altfn_port gpio_altfn_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .rd_valid      (rd_valid),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .port2_rst_req (port2_rst_req),
    .gpe_req       (gpe_req),
    .expint0_n     (expint0_n),
    .alt_q         (alt_q),
    .ien_q         (ien_q),
    .stat_q        (stat_q),
    .irq           (irq)
);

// File: tb/test_gpio_altfn_port.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected values, a monitor compares
// each read response. Pad behaviour is checked directly in the tasks.
module test_gpio_altfn_port;
    localparam int MIN = 10;
    localparam int W   = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         rd_valid;
    logic [W-1:0] rd_data, pad_in, pad_out, pad_oe;
    logic [W-1:0] ext = '0;
    logic         port2_rst_req = 1'b0, port4_rst_req = 1'b0, gpe_req = 1'b0;
    logic         expint0_n, expint2_n, irq;

    int n_checks = 0, n_fail = 0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #2.5 clk = ~clk;

    // Pad model: a driven pad reads back its own value.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_altfn_port #(.MIN_PULSE_CYC(MIN), .ADDR_W(3)) i_gpio_altfn_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .port2_rst_req(port2_rst_req), .port4_rst_req(port4_rst_req),
        .gpe_req(gpe_req), .expint0_n(expint0_n), .expint2_n(expint2_n),
        .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each read response against the scoreboard.
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected read response", rd_data, '0);
            end else begin
                automatic logic [W-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state
        check(pad_oe == '0, "R1 pad_oe after reset", pad_oe, '0);
        check({irq, expint0_n, expint2_n} == 3'b011, "R1 irq/expint after reset",
              W'({irq, expint0_n, expint2_n}), W'(3'b011));
        rd(3'd0, '0, "R1 DIR reset");
        rd(3'd3, '0, "R1 IEN reset");
        rd(3'd4, '0, "R1 STAT reset");
        rd(3'd5, '0, "R1 ALT reset");

        // R2: direction and data
        wr(3'd0, 9'h003);
        wr(3'd1, 9'h001);
        check(pad_oe == 9'h003, "R2 pad_oe", pad_oe, 9'h003);
        check(pad_out[1:0] == 2'b01, "R2 pad_out", W'(pad_out[1:0]), W'(2'b01));
        rd(3'd0, 9'h003, "R11 DIR readback");
        rd(3'd1, 9'h001, "R11 OUT readback");

        // R3: filtered input, pin 11 is bit 8
        idle(MIN + 6);
        rd(3'd2, 9'h001, "R3 IN loopback");
        @(negedge clk); ext[8] = 1'b1;
        rd(3'd2, 9'h001, "R3 IN not yet changed");
        idle(MIN + 6);
        rd(3'd2, 9'h101, "R3 IN pin 11 seen");

        // R4: short pulse rejected, exact-width pulse accepted
        wr(3'd3, 9'h008);
        @(negedge clk); ext[3] = 1'b1;
        idle(MIN - 1);
        ext[3] = 1'b0;
        idle(MIN + 6);
        rd(3'd2, 9'h101, "R4 short pulse IN");
        rd(3'd4, 9'h000, "R4 short pulse STAT");
        @(negedge clk); ext[3] = 1'b1;
        idle(MIN);
        ext[3] = 1'b0;
        idle(MIN + 6);
        rd(3'd4, 9'h008, "R4 exact pulse STAT");
        check(irq == 1'b1, "R7 irq set", W'(irq), W'(1));

        // R5: change on a pin with interrupt disabled
        @(negedge clk); ext[5] = 1'b1;
        idle(MIN + 6);
        rd(3'd2, 9'h121, "R5 IN pin 5");
        rd(3'd4, 9'h008, "R5 STAT unchanged without enable");

        // R7: enable gates irq, status kept
        wr(3'd3, 9'h000);
        check(irq == 1'b0, "R7 irq off when disabled", W'(irq), W'(0));
        rd(3'd4, 9'h008, "R7 STAT kept");
        wr(3'd3, 9'h008);
        check(irq == 1'b1, "R7 irq back", W'(irq), W'(1));

        // R6: write 0 no effect, write 1 clears
        wr(3'd4, 9'h000);
        rd(3'd4, 9'h008, "R6 write zero keeps");
        wr(3'd4, 9'h008);
        rd(3'd4, 9'h000, "R6 write one clears");
        check(irq == 1'b0, "R7 irq after clear", W'(irq), W'(0));

        // R6: set and clear on the same edge, set wins
        @(negedge clk); ext[3] = 1'b1;
        repeat (11) @(negedge clk);
        wr(3'd4, 9'h008);
        rd(3'd4, 9'h008, "R6 set wins over clear");
        wr(3'd4, 9'h008);
        rd(3'd4, 9'h000, "R6 later clear");

        // R8/R9: output alternate functions ignore DIR and OUT
        wr(3'd0, 9'h000);
        wr(3'd1, 9'h1ff);
        port2_rst_req = 1'b1; port4_rst_req = 1'b0; gpe_req = 1'b1;
        wr(3'd5, 9'h013);
        check((pad_oe & 9'h083) == 9'h083, "R8 R9 alt pads enabled", pad_oe & 9'h083, 9'h083);
        check(pad_out[1:0] == 2'b10, "R8 reset outputs", W'(pad_out[1:0]), W'(2'b10));
        check(pad_out[7] == 1'b0, "R9 event output", W'(pad_out[7]), W'(0));
        @(negedge clk); port2_rst_req = 1'b0; port4_rst_req = 1'b1; gpe_req = 1'b0;
        @(negedge clk);
        check(pad_out[1:0] == 2'b01, "R8 reset outputs flipped", W'(pad_out[1:0]), W'(2'b01));
        check(pad_out[7] == 1'b1, "R9 event output released", W'(pad_out[7]), W'(1));
        rd(3'd5, 9'h013, "R11 ALT readback");

        // R10: expander inputs
        wr(3'd0, 9'h014);
        wr(3'd1, 9'h000);
        ext[2] = 1'b0; ext[4] = 1'b1;
        wr(3'd5, 9'h00c);
        idle(MIN + 6);
        check(pad_oe[2] == 1'b0 && pad_oe[4] == 1'b0, "R10 alt inputs not driven",
              W'({pad_oe[4], pad_oe[2]}), '0);
        check({expint2_n, expint0_n} == 2'b10, "R10 expint follow pins",
              W'({expint2_n, expint0_n}), W'(2'b10));
        wr(3'd5, 9'h000);
        check({expint2_n, expint0_n} == 2'b11, "R10 expint idle", W'({expint2_n, expint0_n}), W'(2'b11));
        check(pad_oe[2] == 1'b1, "R2 pin 2 back to GPIO output", W'(pad_oe[2]), W'(1));

        // R11: unmapped address, ALT upper bits
        rd(3'd7, 9'h000, "R11 unmapped address");
        wr(3'd5, 9'h1ff);
        rd(3'd5, 9'h01f, "R11 ALT upper bits zero");

        idle(4);
        check(exp_q.size() == 0, "R11 all reads answered", W'(exp_q.size()), '0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule